// File: doc/BRIEF.md
# DMA Channel Control and Status Block

This block is the register front end and control sequencer for a single memory-to-memory DMA channel. Software reaches it through a simple 32-bit register port (address, write strobe, write data, combinational read data). It keeps the transfer configuration (source, destination, two 20-bit counts, wrap target and a control word) and drives it unchanged to a separate transfer engine. The engine itself, the bus master and any address-extension or security state sit outside this block.

Launching, aborting and resetting the channel are register actions. A launch sends the engine a one-cycle start pulse and marks the channel busy. Busy ends on completion, or on an abort (flush or warm reset) once the engine reports idle. A hard reset wipes the channel at once. Completion raises a sticky flag, which becomes a level interrupt when enabled.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every register reads zero, the engine start pulse and flush request are low, and the interrupt output is low.
- R2: Register byte offsets are: flag 0x00, interrupt enable 0x04, launch 0x08, reset 0x0C, stop 0x10, flush 0x14, control 0x18, source 0x1C, destination 0x20, count one 0x24, count two 0x28, wrap target 0x2C. Source, destination, wrap target and control store all 32 bits. The two counts store only bits 19:0 and read zero above them.
- R3: Writing bit 0 = 1 at the launch offset while the channel is not busy raises busy and gives a one-cycle `eng_start` pulse in the cycle after the write. The launch register bit 0 reads 1 while busy.
- R4: A launch write is ignored while busy, while the flush bit is held, while a warm reset is pending or while hard reset is held.
- R5: `eng_done` high while busy clears busy (launch bit 0 reads 0) and sets flag bit 0 one cycle later.
- R6: Writing a word with bit 0 = 0 at the flag offset clears the flag. Writing bit 0 = 1 leaves it unchanged. A completion in the same cycle as a clear write leaves the flag set.
- R7: `irq` is high exactly when interrupt enable bit 0 and flag bit 0 are both 1.
- R8: Flush bit 0 drives `eng_flush`. While it is held and the channel is busy, busy drops once `eng_idle` is high, without setting the flag. Writing 0 releases it.
- R9: Reset-register bit 0 = 1 while busy makes a warm reset pending: it reads back in reset bit 0 and drives `eng_flush`. When `eng_idle` is high, busy and the pending bit clear and configuration is kept. When not busy, the request has no effect.
- R10: Reset-register bit 1 = 1 holds a hard reset. It reads back in reset bit 1 and clears busy, flag, flush, interrupt enable and all configuration at once. While it is held, configuration and launch writes are ignored. Writing the reset register with bit 1 = 0 releases it.
- R11: The stop offset and every unmapped offset read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_flush | output | 1 | Abort request to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_idle | input | 1 | Engine has no beat in flight |
| cfg_src | output | 32 | Source address |
| cfg_dst | output | 32 | Destination address |
| cfg_len1 | output | 20 | First count |
| cfg_len2 | output | 20 | Second count |
| cfg_jump | output | 32 | Wrap target address |
| cfg_ctrl | output | 32 | Control word |
| irq | output | 1 | Level interrupt |

## Verification
The sensitive collision is a completion pulse from the engine landing in the same cycle as a software write that clears the flag. The bench drives `eng_done` and the flag-clear write on the same falling edge, so both reach the design at one rising edge. It then judges by reading the flag back as 1 and seeing `irq` stay high with the enable set. A second overlap is a hard reset written while a transfer is busy and the flag is set. This is judged by busy, flag, enable and configuration all reading zero immediately afterwards.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned OFS_FLAG  = 32'h00;
  localparam int unsigned OFS_INTEN = 32'h04;
  localparam int unsigned OFS_LAUNCH = 32'h08;
  localparam int unsigned OFS_RESET = 32'h0C;
  localparam int unsigned OFS_STOP  = 32'h10;
  localparam int unsigned OFS_FLUSH = 32'h14;
  localparam int unsigned OFS_CTRL  = 32'h18;
  localparam int unsigned OFS_SRC   = 32'h1C;
  localparam int unsigned OFS_DST   = 32'h20;
  localparam int unsigned OFS_LEN1  = 32'h24;
  localparam int unsigned OFS_LEN2  = 32'h28;
  localparam int unsigned OFS_JUMP  = 32'h2C;

  // wide register slots inside the config bank
  localparam int unsigned W_SRC  = 0;
  localparam int unsigned W_DST  = 1;
  localparam int unsigned W_JUMP = 2;
  localparam int unsigned W_CTRL = 3;
  localparam int unsigned N_WIDE = 4;
  localparam int unsigned N_LEN  = 2;

  // interrupt level from flag and enable
  function automatic logic irq_level(input logic flag, input logic en);
    return flag & en;
  endfunction

  // launch is accepted only from a quiet, unblocked channel
  function automatic logic may_launch(input logic busy, input logic flush,
                                      input logic warm, input logic hard);
    return !(busy | flush | warm | hard);
  endfunction
endpackage

// File: rtl/dmac_cfg_regs.sv
module dmac_cfg_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 20,
  parameter int unsigned N_WIDE = 4,
  parameter int unsigned N_LEN  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic [N_WIDE-1:0]             wr_wide,
  input  logic [N_LEN-1:0]              wr_len,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wdata,
  output logic [N_WIDE-1:0][DATA_W-1:0] wide_q,
  output logic [N_LEN-1:0][LEN_W-1:0]   len_q,
  output logic                          en_q
);
  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wide_q[i] <= '0;
      else if (clr)        wide_q[i] <= '0;
      else if (wr_wide[i]) wide_q[i] <= wdata;
    end
  end

  for (genvar j = 0; j < N_LEN; j++) begin : g_len
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         len_q[j] <= '0;
      else if (clr)       len_q[j] <= '0;
      else if (wr_len[j]) len_q[j] <= wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (clr)   en_q <= 1'b0;
    else if (wr_en) en_q <= wdata[0];
  end
endmodule

// File: rtl/dmac_ctl_seq.sv
module dmac_ctl_seq
  import dmac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_launch,
  input  logic       wr_flag,
  input  logic       wr_reset,
  input  logic       wr_flush,
  input  logic [1:0] wbits,
  input  logic       eng_done,
  input  logic       eng_idle,
  output logic       busy,
  output logic       flag,
  output logic       flush_q,
  output logic       warm_q,
  output logic       hard_q,
  output logic       start_pulse,
  output logic       launch_evt,
  output logic       done_evt,
  output logic       abort_evt,
  output logic       hard_set,
  output logic       cfg_clr
);
  logic hard_rel;
  logic warm_req;

  assign hard_set   = wr_reset & wbits[1];
  assign hard_rel   = wr_reset & ~wbits[1] & hard_q;
  assign cfg_clr    = hard_set | hard_q;
  assign launch_evt = wr_launch & wbits[0] & may_launch(busy, flush_q, warm_q, hard_q);
  assign done_evt   = busy & eng_done;
  assign abort_evt  = busy & ~eng_done & (flush_q | warm_q) & eng_idle;
  assign warm_req   = wr_reset & wbits[0] & busy & ~hard_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      flag        <= 1'b0;
      flush_q     <= 1'b0;
      warm_q      <= 1'b0;
      hard_q      <= 1'b0;
      start_pulse <= 1'b0;
    end else if (hard_set) begin
      busy        <= 1'b0;
      flag        <= 1'b0;
      flush_q     <= 1'b0;
      warm_q      <= 1'b0;
      hard_q      <= 1'b1;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= launch_evt;
      if (hard_rel) hard_q <= 1'b0;
      if (wr_flush && !hard_q) flush_q <= wbits[0];

      if (launch_evt) begin
        busy <= 1'b1;
      end else if (done_evt || abort_evt) begin
        busy   <= 1'b0;
        warm_q <= 1'b0;
      end else if (warm_req) begin
        warm_q <= 1'b1;
      end

      // completion outranks a software clear in the same cycle
      if (done_evt)                flag <= 1'b1;
      else if (wr_flag && !wbits[0]) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dmac_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              eng_start,
  output logic              eng_flush,
  input  logic              eng_done,
  input  logic              eng_idle,
  output logic [DATA_W-1:0] cfg_src,
  output logic [DATA_W-1:0] cfg_dst,
  output logic [LEN_W-1:0]  cfg_len1,
  output logic [LEN_W-1:0]  cfg_len2,
  output logic [DATA_W-1:0] cfg_jump,
  output logic [DATA_W-1:0] cfg_ctrl,
  output logic              irq
);
  localparam int unsigned PAD_LEN = DATA_W - LEN_W;

  logic [N_WIDE-1:0][DATA_W-1:0] wide_q;
  logic [N_LEN-1:0][LEN_W-1:0]   len_q;
  logic [N_WIDE-1:0]             wr_wide;
  logic [N_LEN-1:0]              wr_len;
  logic int_en, busy, flag, flush_q, warm_q, hard_q;
  logic launch_evt, done_evt, abort_evt, hard_set, cfg_clr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_wide[W_SRC]  = bus_wr & hit(bus_addr, OFS_SRC);
  assign wr_wide[W_DST]  = bus_wr & hit(bus_addr, OFS_DST);
  assign wr_wide[W_JUMP] = bus_wr & hit(bus_addr, OFS_JUMP);
  assign wr_wide[W_CTRL] = bus_wr & hit(bus_addr, OFS_CTRL);
  assign wr_len[0]       = bus_wr & hit(bus_addr, OFS_LEN1);
  assign wr_len[1]       = bus_wr & hit(bus_addr, OFS_LEN2);

  dmac_cfg_regs #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .N_WIDE(N_WIDE), .N_LEN(N_LEN)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cfg_clr),
    .wr_wide(wr_wide),
    .wr_len (wr_len),
    .wr_en  (bus_wr & hit(bus_addr, OFS_INTEN)),
    .wdata  (bus_wdata),
    .wide_q (wide_q),
    .len_q  (len_q),
    .en_q   (int_en)
  );

  dmac_ctl_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_launch  (bus_wr & hit(bus_addr, OFS_LAUNCH)),
    .wr_flag    (bus_wr & hit(bus_addr, OFS_FLAG)),
    .wr_reset   (bus_wr & hit(bus_addr, OFS_RESET)),
    .wr_flush   (bus_wr & hit(bus_addr, OFS_FLUSH)),
    .wbits      (bus_wdata[1:0]),
    .eng_done   (eng_done),
    .eng_idle   (eng_idle),
    .busy       (busy),
    .flag       (flag),
    .flush_q    (flush_q),
    .warm_q     (warm_q),
    .hard_q     (hard_q),
    .start_pulse(eng_start),
    .launch_evt (launch_evt),
    .done_evt   (done_evt),
    .abort_evt  (abort_evt),
    .hard_set   (hard_set),
    .cfg_clr    (cfg_clr)
  );

  assign eng_flush = flush_q | warm_q;
  assign irq       = irq_level(flag, int_en);
  assign cfg_src   = wide_q[W_SRC];
  assign cfg_dst   = wide_q[W_DST];
  assign cfg_jump  = wide_q[W_JUMP];
  assign cfg_ctrl  = wide_q[W_CTRL];
  assign cfg_len1  = len_q[0];
  assign cfg_len2  = len_q[1];

  always_comb begin
    bus_rdata = '0;
    if      (hit(bus_addr, OFS_FLAG))   bus_rdata[0] = flag;
    else if (hit(bus_addr, OFS_INTEN))  bus_rdata[0] = int_en;
    else if (hit(bus_addr, OFS_LAUNCH)) bus_rdata[0] = busy;
    else if (hit(bus_addr, OFS_RESET))  bus_rdata[1:0] = {hard_q, warm_q};
    else if (hit(bus_addr, OFS_FLUSH))  bus_rdata[0] = flush_q;
    else if (hit(bus_addr, OFS_CTRL))   bus_rdata = wide_q[W_CTRL];
    else if (hit(bus_addr, OFS_SRC))    bus_rdata = wide_q[W_SRC];
    else if (hit(bus_addr, OFS_DST))    bus_rdata = wide_q[W_DST];
    else if (hit(bus_addr, OFS_JUMP))   bus_rdata = wide_q[W_JUMP];
    else if (hit(bus_addr, OFS_LEN1))   bus_rdata = {{PAD_LEN{1'b0}}, len_q[0]};
    else if (hit(bus_addr, OFS_LEN2))   bus_rdata = {{PAD_LEN{1'b0}}, len_q[1]};
  end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              flag,
  input logic              int_en,
  input logic              irq,
  input logic              eng_start,
  input logic              eng_done,
  input logic              eng_idle,
  input logic              hard_q,
  input logic              hard_set,
  input logic              warm_q,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata
);
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_start_marks_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (busy && !$past(busy)));

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && !hard_set) |=> !busy);

  assert_done_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && !hard_set) |=> flag);

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);

  assert_irq_when_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && int_en) |-> irq);

  assert_busy_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(eng_done || eng_idle || hard_set));

  assert_warm_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q |-> busy);

  assert_hard_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hard_q |-> (!busy && !flag && !int_en));

  assert_len_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(8'h24) || bus_addr == ADDR_W'(8'h28))
      |-> (bus_rdata[DATA_W-1:LEN_W] == '0));
endmodule

bind dma_chan_ctrl dmac_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .flag     (flag),
  .int_en   (int_en),
  .irq      (irq),
  .eng_start(eng_start),
  .eng_done (eng_done),
  .eng_idle (eng_idle),
  .hard_q   (hard_q),
  .hard_set (hard_set),
  .warm_q   (warm_q),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_start, eng_flush, irq;
  logic        eng_done = 1'b0;
  logic        eng_idle = 1'b1;
  logic [31:0] cfg_src, cfg_dst, cfg_jump, cfg_ctrl;
  logic [19:0] cfg_len1, cfg_len2;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  q_addr[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  dma_chan_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
    .eng_flush(eng_flush), .eng_done(eng_done), .eng_idle(eng_idle),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len1(cfg_len1),
    .cfg_len2(cfg_len2), .cfg_jump(cfg_jump), .cfg_ctrl(cfg_ctrl), .irq(irq)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compares each queued read item a quarter period after its edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q_exp.size() > 0) begin
      logic [7:0]  a;
      logic [31:0] e;
      string       t;
      a = q_addr.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk(bus_rdata, e, $sformatf("%s read @%h", t, a));
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    q_addr.push_back(a);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(posedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1 irq");
    chk({31'd0, eng_start}, 32'd0, "R1 eng_start");
    chk({31'd0, eng_flush}, 32'd0, "R1 eng_flush");
    rd(8'h08, 32'd0, "R1 launch");
    rd(8'h00, 32'd0, "R1 flag");
    rd(8'h1C, 32'd0, "R1 src");

    // R2 configuration storage and count masking
    wr(8'h1C, 32'hA5A5_0001);
    wr(8'h20, 32'h5A5A_0002);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h28, 32'h1234_5678);
    wr(8'h2C, 32'hDEAD_BEEF);
    wr(8'h18, 32'h0012_3456);
    rd(8'h1C, 32'hA5A5_0001, "R2 src");
    rd(8'h20, 32'h5A5A_0002, "R2 dst");
    rd(8'h24, 32'h000F_FFFF, "R2 len1");
    rd(8'h28, 32'h0004_5678, "R2 len2");
    rd(8'h2C, 32'hDEAD_BEEF, "R2 jump");
    rd(8'h18, 32'h0012_3456, "R2 ctrl");
    chk({12'd0, cfg_len1}, 32'h000F_FFFF, "R2 cfg_len1 port");

    // R11 stop and unmapped offsets
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'd0, "R11 stop");
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, 32'd0, "R11 unmapped");
    rd(8'h1C, 32'hA5A5_0001, "R11 src untouched");

    // R3 launch
    wr(8'h08, 32'd1);
    chk({31'd0, eng_start}, 32'd1, "R3 start pulse");
    @(negedge clk);
    chk({31'd0, eng_start}, 32'd0, "R3 start one cycle");
    rd(8'h08, 32'd1, "R3 busy readback");

    // R4 launch ignored while busy
    wr(8'h08, 32'd1);
    chk({31'd0, eng_start}, 32'd0, "R4 no pulse while busy");

    // R5 completion, R7 interrupt, R6 clear rules
    pulse_done();
    rd(8'h08, 32'd0, "R5 busy cleared");
    rd(8'h00, 32'd1, "R5 flag set");
    chk({31'd0, irq}, 32'd0, "R7 masked");
    wr(8'h04, 32'd1);
    chk({31'd0, irq}, 32'd1, "R7 irq high");
    wr(8'h00, 32'd1);
    rd(8'h00, 32'd1, "R6 write one keeps flag");
    wr(8'h00, 32'd0);
    rd(8'h00, 32'd0, "R6 write zero clears");
    chk({31'd0, irq}, 32'd0, "R7 irq low after clear");

    // R6 collision: completion and clear in the same cycle
    wr(8'h08, 32'd1);
    @(negedge clk);
    eng_done = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'd0;
    @(negedge clk);
    eng_done = 1'b0; bus_wr = 1'b0;
    rd(8'h00, 32'd1, "R6 set wins over clear");
    chk({31'd0, irq}, 32'd1, "R6 irq stays");
    wr(8'h00, 32'd0);

    // R8 flush abort
    eng_idle = 1'b0;
    wr(8'h08, 32'd1);
    wr(8'h14, 32'd1);
    chk({31'd0, eng_flush}, 32'd1, "R8 flush driven");
    rd(8'h08, 32'd1, "R8 busy until idle");
    @(negedge clk);
    eng_idle = 1'b1;
    @(negedge clk);
    rd(8'h08, 32'd0, "R8 aborted");
    rd(8'h00, 32'd0, "R8 no flag on abort");
    wr(8'h08, 32'd1);
    chk({31'd0, eng_start}, 32'd0, "R4 no launch with flush held");
    wr(8'h14, 32'd0);
    chk({31'd0, eng_flush}, 32'd0, "R8 flush released");

    // R9 warm reset
    eng_idle = 1'b0;
    wr(8'h08, 32'd1);
    wr(8'h0C, 32'd1);
    rd(8'h0C, 32'd1, "R9 warm pending");
    chk({31'd0, eng_flush}, 32'd1, "R9 warm drives flush");
    rd(8'h08, 32'd1, "R9 busy while engine active");
    @(negedge clk);
    eng_idle = 1'b1;
    @(negedge clk);
    rd(8'h08, 32'd0, "R9 busy dropped");
    rd(8'h0C, 32'd0, "R9 pending cleared");
    rd(8'h1C, 32'hA5A5_0001, "R9 config kept");
    wr(8'h0C, 32'd1);
    rd(8'h0C, 32'd0, "R9 no effect when idle");

    // R10 hard reset while busy with flag set
    wr(8'h08, 32'd1);
    pulse_done();
    wr(8'h08, 32'd1);
    rd(8'h08, 32'd1, "R10 busy before hard");
    wr(8'h0C, 32'd2);
    rd(8'h0C, 32'd2, "R10 hold readback");
    rd(8'h08, 32'd0, "R10 busy cleared");
    rd(8'h00, 32'd0, "R10 flag cleared");
    rd(8'h04, 32'd0, "R10 enable cleared");
    rd(8'h1C, 32'd0, "R10 src cleared");
    rd(8'h24, 32'd0, "R10 len1 cleared");
    chk({31'd0, irq}, 32'd0, "R10 irq low");
    wr(8'h1C, 32'h1111_2222);
    rd(8'h1C, 32'd0, "R10 config write ignored");
    wr(8'h08, 32'd1);
    chk({31'd0, eng_start}, 32'd0, "R4 no launch in hard hold");
    wr(8'h0C, 32'd0);
    rd(8'h0C, 32'd0, "R10 released");
    wr(8'h08, 32'd1);
    chk({31'd0, eng_start}, 32'd1, "R10 launch after release");
    pulse_done();
    rd(8'h00, 32'd1, "R5 second completion");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule